// File: doc/BRIEF.md
# Remappable Flit FIFO

A synchronous first-in first-out buffer for network flits in which the read and write pointers never address storage directly. Each pointer value is a logical slot number that is looked up in a small remap table; the table returns the physical storage cell to use. Cells found faulty by a self-test unit are simply given no logical slot, so the pointers step over them. The table entry that carries a wrap mark ends the logical ring, and the buffer then behaves exactly like a shallower FIFO. It stays usable while at least one cell is good.

After reset the table is the identity map with the wrap mark on the final slot, so the block is an ordinary FIFO of `DEPTH` flits. A diagnosis unit raises `cfg_en_i`, which empties the buffer and rewinds both pointers, and writes table entries through the configuration port. It then drops `cfg_en_i` and traffic resumes at the reduced depth. The head flit is presented combinationally on `pop_data_o` whenever the buffer holds data.

Top module: `remap_fifo`

## Requirements
- R1: After reset the buffer is empty (`empty_o`=1, `full_o`=0, `count_o`=0) and the table is the identity map with the wrap mark only on slot `DEPTH-1`.
- R2: Flits leave in the order they entered; with the reset map, `full_o` rises after exactly `DEPTH` accepted pushes.
- R3: A push while `full_o` is high is dropped: count and queued data are unchanged.
- R4: A pop while `empty_o` is high is dropped: count stays 0 and a later push/pop returns the pushed flit.
- R5: A push and a pop in the same cycle on a buffer that is neither full nor empty leave `count_o` unchanged and keep the order.
- R6: While `cfg_en_i` is high the buffer is flushed: `count_o`=0, `empty_o`=1, both pointers back at slot 0; push and pop are ignored.
- R7: A table write (`cfg_we_i`=1) is accepted only when `cfg_en_i` is high; otherwise the table is unchanged.
- R8: The effective depth is one more than the lowest slot whose wrap mark is set (`cfg_last_i`=1 when written); `full_o` rises at that count, and both pointers return to slot 0 after that slot, preserving order over many wraps.
- R9: Storage is addressed through the table: slot `cfg_addr_i` uses physical cell `cfg_phys_i`, so two slots given the same cell share its contents.
- R10: With the wrap mark on slot 0 the buffer works as a one-flit FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_en_i | input | 1 | Reconfiguration mode: flushes and opens the table for writes |
| cfg_we_i | input | 1 | Table write strobe |
| cfg_addr_i | input | IDX_W | Logical slot to write |
| cfg_phys_i | input | IDX_W | Physical cell for that slot |
| cfg_last_i | input | 1 | Wrap mark for that slot |
| push_i | input | 1 | Write request |
| push_data_i | input | DATA_W | Flit to write |
| pop_i | input | 1 | Read request |
| pop_data_o | output | DATA_W | Flit at the head of the queue |
| full_o | output | 1 | Occupancy equals effective depth |
| empty_o | output | 1 | Occupancy is zero |
| count_o | output | IDX_W+1 | Current occupancy |

## Verification
A corrupted table entry shows up at `pop_data_o` on the first pass of the pointer over that slot, either as a lost or repeated flit, so ordering checks that wrap several times catch it within one ring length. A wrong wrap decision shows in the very cycle the count reaches the intended depth, as `full_o` rising early or late. Count errors surface immediately on `count_o` and in the flag pair, and a flush that misses a pointer appears as misordered data on the first flit after configuration.

// File: rtl/remap_fifo_pkg.sv
package remap_fifo_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_PUSH = 2'b01,
    OP_POP  = 2'b10,
    OP_BOTH = 2'b11
  } fifo_op_e;
endpackage

// File: rtl/remap_table.sv
module remap_table #(
  parameter int DEPTH = 32,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_en_i,
  input  logic             cfg_we_i,
  input  logic [IDX_W-1:0] cfg_addr_i,
  input  logic [IDX_W-1:0] cfg_phys_i,
  input  logic             cfg_last_i,
  input  logic [IDX_W-1:0] wr_slot_i,
  input  logic [IDX_W-1:0] rd_slot_i,
  output logic [IDX_W-1:0] wr_phys_o,
  output logic [IDX_W-1:0] rd_phys_o,
  output logic [IDX_W:0]   eff_depth_o
);
  logic [IDX_W-1:0] phys_q [DEPTH];
  logic             last_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        phys_q[g] <= IDX_W'(g);
        last_q[g] <= (g == DEPTH - 1);
      end else if (cfg_en_i && cfg_we_i && cfg_addr_i == IDX_W'(g)) begin
        phys_q[g] <= cfg_phys_i;
        last_q[g] <= cfg_last_i;
      end
    end

    // R7
    table_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cfg_en_i |=> $stable(phys_q[g]) && $stable(last_q[g]));
  end

  // lowest marked slot ends the ring
  always_comb begin
    eff_depth_o = (IDX_W + 1)'(DEPTH);
    for (int i = DEPTH - 1; i >= 0; i--)
      if (last_q[i]) eff_depth_o = (IDX_W + 1)'(i + 1);
  end

  assign wr_phys_o = phys_q[wr_slot_i];
  assign rd_phys_o = phys_q[rd_slot_i];
endmodule

// File: rtl/fifo_ptr_ctrl.sv
module fifo_ptr_ctrl
  import remap_fifo_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_en_i,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [IDX_W:0]   eff_depth_i,
  output logic [IDX_W-1:0] wr_slot_o,
  output logic [IDX_W-1:0] rd_slot_o,
  output logic [IDX_W:0]   count_o,
  output logic             full_o,
  output logic             empty_o,
  output logic             wr_en_o
);
  logic [IDX_W-1:0] wr_q, rd_q;
  logic [IDX_W:0]   cnt_q;
  logic             rd_en;
  fifo_op_e         op;

  function automatic logic [IDX_W-1:0] next_slot(logic [IDX_W-1:0] s, logic [IDX_W:0] lim);
    return (({1'b0, s} + 1'b1) == lim) ? '0 : s + 1'b1;
  endfunction

  assign full_o  = (cnt_q == eff_depth_i);
  assign empty_o = (cnt_q == '0);
  assign wr_en_o = push_i && !full_o && !cfg_en_i;
  assign rd_en   = pop_i && !empty_o && !cfg_en_i;
  assign op      = fifo_op_e'({rd_en, wr_en_o});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (cfg_en_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (wr_en_o) wr_q <= next_slot(wr_q, eff_depth_i);
      if (rd_en)   rd_q <= next_slot(rd_q, eff_depth_i);
      unique case (op)
        OP_PUSH: cnt_q <= cnt_q + 1'b1;
        OP_POP:  cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign wr_slot_o = wr_q;
  assign rd_slot_o = rd_q;
  assign count_o   = cnt_q;

  // R3
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= eff_depth_i);
  // R4
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0 && !push_i) |=> cnt_q == '0);
  // R5
  both_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i && !cfg_en_i && cnt_q != '0 && cnt_q < eff_depth_i) |=> $stable(cnt_q));
  // R6
  flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_en_i |=> (cnt_q == '0 && wr_q == '0 && rd_q == '0));
endmodule

// File: rtl/fifo_store.sv
module fifo_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 32,
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i)
    if (we_i) mem_q[waddr_i] <= wdata_i;

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/remap_fifo.sv
module remap_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 32,
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_en_i,
  input  logic              cfg_we_i,
  input  logic [IDX_W-1:0]  cfg_addr_i,
  input  logic [IDX_W-1:0]  cfg_phys_i,
  input  logic              cfg_last_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] pop_data_o,
  output logic              full_o,
  output logic              empty_o,
  output logic [IDX_W:0]    count_o
);
  logic [IDX_W-1:0] wr_slot, rd_slot, wr_phys, rd_phys;
  logic [IDX_W:0]   eff_depth;
  logic             wr_en;

  remap_table #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_table (
    .clk_i, .rst_ni, .cfg_en_i, .cfg_we_i, .cfg_addr_i, .cfg_phys_i, .cfg_last_i,
    .wr_slot_i(wr_slot), .rd_slot_i(rd_slot),
    .wr_phys_o(wr_phys), .rd_phys_o(rd_phys), .eff_depth_o(eff_depth)
  );

  fifo_ptr_ctrl #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_ptr (
    .clk_i, .rst_ni, .cfg_en_i, .push_i, .pop_i,
    .eff_depth_i(eff_depth),
    .wr_slot_o(wr_slot), .rd_slot_o(rd_slot),
    .count_o, .full_o, .empty_o, .wr_en_o(wr_en)
  );

  fifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
    .clk_i, .we_i(wr_en), .waddr_i(wr_phys), .wdata_i(push_data_i),
    .raddr_i(rd_phys), .rdata_o(pop_data_o)
  );

  // R2
  flags_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o));
endmodule

// File: tb/remap_fifo_bench.sv
module remap_fifo_bench;
  localparam int DATA_W = 32;
  localparam int DEPTH  = 32;
  localparam int IDX_W  = $clog2(DEPTH);

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_en = 0, cfg_we = 0, cfg_last = 0, push = 0, pop = 0;
  logic [IDX_W-1:0] cfg_addr = '0, cfg_phys = '0;
  logic [DATA_W-1:0] push_data = '0, pop_data;
  logic full, empty;
  logic [IDX_W:0] count;
  int n_chk = 0, n_err = 0;

  always #5 clk = ~clk;

  remap_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_remap_fifo (
    .clk_i(clk), .rst_ni(rst_n), .cfg_en_i(cfg_en), .cfg_we_i(cfg_we),
    .cfg_addr_i(cfg_addr), .cfg_phys_i(cfg_phys), .cfg_last_i(cfg_last),
    .push_i(push), .push_data_i(push_data), .pop_i(pop),
    .pop_data_o(pop_data), .full_o(full), .empty_o(empty), .count_o(count)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  // all drives start at a falling edge and end at the next one
  task automatic step(input logic ps, input logic [DATA_W-1:0] d, input logic pp);
    push = ps; push_data = d; pop = pp;
    @(posedge clk); @(negedge clk);
    push = 0; pop = 0;
  endtask

  task automatic pop_exp(input logic [DATA_W-1:0] exp, input string req);
    chk(pop_data === exp, req, pop_data, exp);
    step(0, '0, 1);
  endtask

  task automatic cfg_wr(input int a, input int p, input logic l);
    cfg_en = 1; cfg_we = 1; cfg_addr = IDX_W'(a); cfg_phys = IDX_W'(p); cfg_last = l;
    @(posedge clk); @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic flush();
    cfg_en = 1; @(posedge clk); @(negedge clk); cfg_en = 0;
  endtask

  task automatic restore_identity();
    for (int i = 0; i < DEPTH; i++) cfg_wr(i, i, i == DEPTH - 1);
    cfg_en = 0;
  endtask

  task automatic t_reset();
    chk(empty === 1 && full === 0 && count === 0, "R1 reset flags", {full, empty, count}, 2'b01 << (IDX_W + 1));
  endtask

  task automatic t_fill();
    for (int i = 0; i < DEPTH; i++) begin
      chk(full === 0, "R2 not full early", full, 0);
      step(1, 32'hA000_0000 + i, 0);
    end
    chk(full === 1 && count === DEPTH, "R2 full at DEPTH", count, DEPTH);
    step(1, 32'hDEAD_BEEF, 0);
    chk(count === DEPTH, "R3 push when full dropped", count, DEPTH);
    for (int i = 0; i < DEPTH; i++) pop_exp(32'hA000_0000 + i, "R2 order / R3 data kept");
    chk(empty === 1, "R2 empty after drain", empty, 1);
  endtask

  task automatic t_underflow();
    step(0, '0, 1);
    chk(count === 0 && empty === 1, "R4 pop when empty dropped", count, 0);
    step(1, 32'h0000_0055, 0);
    pop_exp(32'h0000_0055, "R4 next flit intact");
  endtask

  task automatic t_both();
    step(1, 32'h11, 0); step(1, 32'h22, 0);
    step(1, 32'h33, 1);
    chk(count === 2, "R5 count held on push+pop", count, 2);
    pop_exp(32'h22, "R5 order"); pop_exp(32'h33, "R5 order");
  endtask

  task automatic t_flush();
    step(1, 32'h1, 0); step(1, 32'h2, 0); step(1, 32'h3, 0);
    cfg_en = 1; push = 1; push_data = 32'h99;
    @(posedge clk); @(negedge clk);
    cfg_en = 0; push = 0;
    chk(count === 0 && empty === 1, "R6 flush clears", count, 0);
    step(1, 32'h44, 0);
    pop_exp(32'h44, "R6 pointers rewound");
  endtask

  task automatic t_cfg_gate();
    cfg_we = 1; cfg_addr = '0; cfg_phys = IDX_W'(3); cfg_last = 1;
    @(posedge clk); @(negedge clk);
    cfg_we = 0;
    step(1, 32'h77, 0);
    chk(full === 0, "R7 write ignored without cfg_en", full, 0);
    step(1, 32'h78, 0);
    pop_exp(32'h77, "R7 map unchanged");
    pop_exp(32'h78, "R7 map unchanged");
  endtask

  task automatic t_short_wrap();
    logic [DATA_W-1:0] q [$];
    int ids [5] = '{0, 1, 3, 4, 6};
    for (int i = 0; i < 5; i++) cfg_wr(i, ids[i], i == 4);
    cfg_en = 0;
    for (int i = 0; i < 5; i++) begin
      chk(full === 0, "R8 not full early", count, i);
      step(1, 32'hB000 + i, 0); q.push_back(32'hB000 + i);
    end
    chk(full === 1 && count === 5, "R8 full at effective depth", count, 5);
    pop_exp(q.pop_front(), "R8 order");
    for (int r = 0; r < 17; r++) begin
      chk(pop_data === q[0], "R8 order across wraps", pop_data, q[0]);
      step(1, 32'hC000 + r, 1);
      void'(q.pop_front()); q.push_back(32'hC000 + r);
    end
    chk(count === 4, "R8 count after wraps", count, 4);
    while (q.size() > 0) pop_exp(q.pop_front(), "R8 drain after wraps");
    restore_identity();
  endtask

  task automatic t_alias();
    cfg_wr(0, 5, 0); cfg_wr(1, 5, 0); cfg_wr(2, 2, 0); cfg_wr(3, 3, 1);
    cfg_en = 0;
    step(1, 32'hAAAA, 0); step(1, 32'hBBBB, 0);
    pop_exp(32'hBBBB, "R9 slot 0 uses shared cell");
    pop_exp(32'hBBBB, "R9 slot 1 uses shared cell");
    restore_identity();
  endtask

  task automatic t_single();
    cfg_wr(0, 7, 1); cfg_en = 0;
    step(1, 32'h1234, 0);
    chk(full === 1 && count === 1, "R10 full with one flit", count, 1);
    step(1, 32'h5678, 0);
    pop_exp(32'h1234, "R10 second push dropped");
    chk(empty === 1, "R10 empty", empty, 1);
    step(1, 32'h9ABC, 0);
    pop_exp(32'h9ABC, "R10 reuse after wrap");
    restore_identity();
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=hung expected=done");
    summary();
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_fill();
    t_underflow();
    t_both();
    t_flush();
    t_cfg_gate();
    t_short_wrap();
    t_alias();
    t_single();
    t_fill();
    summary();
  end
endmodule